// File: doc/BRIEF.md
# Write-Completion Status Read Path

This block drives the read data of a byte-wide non-volatile memory while an internal programming cycle runs and after it ends. While the memory is busy, a read returns a status word built from the last byte written, not array contents. Bit 7 carries the complemented polling bit. Bit 6 is a toggle bit that inverts on every new read access. Bits 5:0 echo the last byte written. Once the busy flag drops, reads return the array data again.

A read is active only while both active-low enables are low. Otherwise the output enable is deasserted and the data lines are held at zero. Some writes are refused because protection is on. The controller flags such a busy period with `refused_i`. During it the polling bit is not inverted, but the toggle bit still shows that the memory is busy.

All outputs are registered and follow the inputs by one clock.

Top module: `wr_status_rdpath`

## Requirements
- R1: While `rst_ni` is low, `data_oe_o` is 0 and `data_o` is all zeros.
- R2: If `ce_ni` or `oe_ni` is high at a clock edge, then after that edge `data_oe_o` is 0 and `data_o` is zero. If both are low, `data_oe_o` is 1.
- R3: A read with `busy_i` low returns `array_i` on `data_o`, registered at the clock edge where the read is sampled.
- R4: A read with `busy_i` high and `refused_i` low returns bit 7 equal to the inverse of bit 7 of `last_byte_i`.
- R5: A read with `busy_i` high returns bits 5:0 equal to bits 5:0 of `last_byte_i`.
- R6: While busy, bit 6 inverts once at the first clock edge of each new read access. A new access is a clock where both enables are low after a clock where they were not. Bit 6 holds its value for the rest of that access.
- R7: The toggle state is cleared when `busy_i` rises, so the first read access of each programming cycle returns bit 6 = 1.
- R8: A read with `busy_i` and `refused_i` both high returns bit 7 equal to bit 7 of `last_byte_i`, and bit 6 still toggles per access.
- R9: Once `busy_i` is low, bit 6 no longer toggles: repeated reads return exactly `array_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| busy_i | input | 1 | Internal programming cycle in progress |
| refused_i | input | 1 | Current busy period comes from a write refused by protection |
| last_byte_i | input | 8 | Last byte presented for writing |
| array_i | input | 8 | Array data at the addressed location |
| data_o | output | 8 | Read data |
| data_oe_o | output | 1 | Drive enable for the data bus |

## Verification
Every result is due one clock after the stimulus that causes it. The bench changes inputs on the falling clock edge and samples on the next falling edge, after exactly one rising edge. The toggle model flips its expected bit only when a fresh access starts while busy, and clears when busy is raised. Multi-cycle accesses are sampled on every cycle, so any extra inversion within an access shows up as a mismatch.

// File: rtl/wr_status_pkg.sv
package wr_status_pkg;
  typedef enum logic {SRC_ARRAY = 1'b0, SRC_STATUS = 1'b1} rd_src_e;
endpackage

// File: rtl/wr_rd_strobe.sv
module wr_rd_strobe (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic oe_ni,
  output logic rd_act_o,
  output logic rd_new_o
);
  logic rd_q;
  assign rd_act_o = ~ce_ni & ~oe_ni;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= 1'b0;
    else         rd_q <= rd_act_o;
  end
  assign rd_new_o = rd_act_o & ~rd_q;
endmodule

// File: rtl/wr_toggle_gen.sv
module wr_toggle_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  input  logic rd_new_i,
  output logic tgl_o
);
  logic busy_q, tgl_q, tgl_base, tgl_d;
  always_comb begin
    tgl_base = (busy_i & ~busy_q) ? 1'b0 : tgl_q;
    tgl_d    = (busy_i & rd_new_i) ? ~tgl_base : tgl_base;
  end
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      tgl_q  <= 1'b0;
    end else begin
      busy_q <= busy_i;
      tgl_q  <= tgl_d;
    end
  end
  // next value, so the registered output shows the flip of this access
  assign tgl_o = tgl_d;
endmodule

// File: rtl/wr_stat_mux.sv
module wr_stat_mux
  import wr_status_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int POLL_BIT = 7,
  parameter int TGL_BIT  = 6
) (
  input  rd_src_e           src_i,
  input  logic              refused_i,
  input  logic              tgl_i,
  input  logic [DATA_W-1:0] last_byte_i,
  input  logic [DATA_W-1:0] array_i,
  output logic [DATA_W-1:0] word_o
);
  logic [DATA_W-1:0] stat_w;
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i == POLL_BIT) begin : g_poll
      assign stat_w[i] = last_byte_i[i] ^ ~refused_i;
    end else if (i == TGL_BIT) begin : g_tgl
      assign stat_w[i] = tgl_i;
    end else begin : g_echo
      assign stat_w[i] = last_byte_i[i];
    end
  end
  assign word_o = (src_i == SRC_STATUS) ? stat_w : array_i;
endmodule

// File: rtl/wr_status_rdpath.sv
module wr_status_rdpath
  import wr_status_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int POLL_BIT = DATA_W - 1,
  parameter int TGL_BIT  = DATA_W - 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              busy_i,
  input  logic              refused_i,
  input  logic [DATA_W-1:0] last_byte_i,
  input  logic [DATA_W-1:0] array_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);
  logic              rd_act, rd_new, tgl;
  logic [DATA_W-1:0] word;
  rd_src_e           src;

  assign src = busy_i ? SRC_STATUS : SRC_ARRAY;

  wr_rd_strobe u_strobe (
    .clk_i, .rst_ni, .ce_ni, .oe_ni,
    .rd_act_o(rd_act), .rd_new_o(rd_new)
  );

  wr_toggle_gen u_tgl (
    .clk_i, .rst_ni, .busy_i,
    .rd_new_i(rd_new), .tgl_o(tgl)
  );

  wr_stat_mux #(.DATA_W(DATA_W), .POLL_BIT(POLL_BIT), .TGL_BIT(TGL_BIT)) u_mux (
    .src_i(src), .refused_i, .tgl_i(tgl),
    .last_byte_i, .array_i, .word_o(word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_oe_o <= 1'b0;
      data_o    <= '0;
    end else begin
      data_oe_o <= rd_act;
      data_o    <= rd_act ? word : '0;
    end
  end
endmodule

// File: rtl/wr_status_rdpath_chk.sv
module wr_status_rdpath_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ce_ni,
  input logic              oe_ni,
  input logic              busy_i,
  input logic              refused_i,
  input logic [DATA_W-1:0] last_byte_i,
  input logic [DATA_W-1:0] array_i,
  input logic [DATA_W-1:0] data_o,
  input logic              data_oe_o
);
  logic rd;
  assign rd = ~ce_ni & ~oe_ni;

  always_comb begin
    if (!rst_ni) a_r1_reset_quiet: assert (!data_oe_o && data_o == '0);
  end

  a_r2_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> (!data_oe_o && data_o == '0));
  a_r2_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd |=> data_oe_o);
  a_r3_array: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && !busy_i) |=> data_o == $past(array_i));
  a_r4_poll_inv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && busy_i && !refused_i) |=> data_o[DATA_W-1] == !$past(last_byte_i[DATA_W-1]));
  a_r5_low_echo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && busy_i) |=> data_o[DATA_W-3:0] == $past(last_byte_i[DATA_W-3:0]));
  a_r6_hold_in_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && data_oe_o && busy_i && $past(busy_i)) |=> data_o[DATA_W-2] == $past(data_o[DATA_W-2]));
  a_r8_refused_true: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && busy_i && refused_i) |=> data_o[DATA_W-1] == $past(last_byte_i[DATA_W-1]));
endmodule

bind wr_status_rdpath wr_status_rdpath_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i, .rst_ni, .ce_ni, .oe_ni, .busy_i, .refused_i,
  .last_byte_i, .array_i, .data_o, .data_oe_o
);

// File: tb/wr_status_rdpath_bench.sv
`timescale 1ns/1ps
module wr_status_rdpath_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, busy = 1'b0, refused = 1'b0;
  logic [7:0] last_b = '0, arr = '0, data;
  logic data_oe;
  int total = 0, bad = 0;
  bit exp_tgl = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wr_status_rdpath u_wr_status_rdpath (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .oe_ni(oe_n),
    .busy_i(busy), .refused_i(refused), .last_byte_i(last_b),
    .array_i(arr), .data_o(data), .data_oe_o(data_oe)
  );

  task automatic chk(string req, logic [8:0] act, logic [8:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  function automatic logic [7:0] stat_exp(logic [7:0] lb, bit tg, bit rf);
    return {lb[7] ^ ~rf, tg, lb[5:0]};
  endfunction

  // one access of n cycles; busy model flips toggle at access start
  task automatic access(string req, int n);
    ce_n = 1'b0; oe_n = 1'b0;
    if (busy) exp_tgl = ~exp_tgl;
    for (int c = 0; c < n; c++) begin
      step();
      if (busy) chk(req, {data_oe, data}, {1'b1, stat_exp(last_b, exp_tgl, refused)});
      else      chk(req, {data_oe, data}, {1'b1, arr});
    end
    ce_n = 1'b1;
    step();
    chk("R2", {data_oe, data}, 9'h000);
  endtask

  task automatic start_busy(bit rf);
    busy = 1'b1; refused = rf; exp_tgl = 1'b0;
    step();
  endtask

  initial begin
    #3;
    chk("R1", {data_oe, data}, 9'h000);
    @(negedge clk); @(negedge clk);
    chk("R1", {data_oe, data}, 9'h000);
    rst_n = 1'b1;
    step();
    // R2: each non-reading enable combination
    for (int k = 1; k < 4; k++) begin
      ce_n = k[0]; oe_n = k[1]; arr = 8'hA5;
      step();
      chk("R2", {data_oe, data}, 9'h000);
    end
    ce_n = 1'b1; oe_n = 1'b1;
    // R3: idle reads across all array values
    for (int v = 0; v < 256; v++) begin
      arr = 8'(v);
      access("R3", 1);
    end
    // R4 R5 R6 R7: busy reads across all last-byte values
    start_busy(1'b0);
    arr = 8'h3C;
    for (int v = 0; v < 256; v++) begin
      last_b = 8'(v);
      access("R4_R5_R6", 1);
    end
    // R6: long access holds bit 6
    last_b = 8'h81;
    access("R6", 4);
    access("R6", 3);
    // R9: after busy falls, repeated reads give array data
    busy = 1'b0; step();
    for (int v = 0; v < 6; v++) begin
      arr = 8'(v * 37 + 1);
      access("R9", 2);
    end
    // R7: new cycle restarts toggle so first read shows bit 6 = 1
    start_busy(1'b0);
    last_b = 8'h00;
    ce_n = 1'b0; oe_n = 1'b0;
    step();
    chk("R7", {data_oe, data}, {1'b1, 8'hC0});
    ce_n = 1'b1; step();
    exp_tgl = 1'b1;
    busy = 1'b0; step();
    // R8: refused write, polling bit true, toggle continues
    start_busy(1'b1);
    for (int v = 0; v < 64; v++) begin
      last_b = 8'(v * 5 + 3);
      access("R8", 1 + (v % 3));
    end
    busy = 1'b0; refused = 1'b0; step();
    arr = 8'hE7;
    access("R9", 2);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule